// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter

This block decides which of several bus masters (three by default) may drive a shared bus. Each master has a dedicated request input, grant output and acknowledge input. When the bus is free, the arbiter grants one requester. The granted master then takes the bus by raising its acknowledge and lowering its request, and the arbiter withdraws the grant. The master keeps the bus for as many transfers as it likes, a burst, until it lowers its acknowledge again.

The order in which masters are favoured moves one place after every finished tenure. The order starts as 0,1,2, then becomes 1,2,0, then 2,0,1, and then wraps. This keeps access fair under steady load. Requests that arrive while the bus is owned stay pending. They are settled in the order in force once the bus is free.

Top module: `rot_bus_arbiter`

## Requirements
- R1: After reset no grant is asserted, and the priority order is master 0 highest, then master 1, then master 2.
- R2: While the bus is free, a request sampled on a clock edge produces that master's grant in the following cycle.
- R3: The priority order moves by one position (the first-ranked master becomes last) at the end of every tenure, whichever master owned the bus.
- R4: Requests raised while the bus is owned get no grant during the tenure. On release, there is one cycle with no grant, and then the highest-ranked pending requester under the rotated order is granted.
- R5: The grant is withdrawn in the cycle after the granted master's acknowledge is sampled high.
- R6: A grant stays asserted until its own master acknowledges, even if that master drops its request. Acknowledges from other masters have no effect on it.
- R7: Once the owner has acknowledged, no grant is asserted to any master until the owner's acknowledge is sampled low.
- R8: At most one grant output is high in any cycle.
- R9: When several masters request in the same free cycle, the one ranked highest under the current order is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_MASTERS | Bus request, bit k from master k |
| ack_i | input | N_MASTERS | Grant acknowledge / bus-busy, bit k from master k |
| gnt_o | output | N_MASTERS | Bus grant, bit k to master k, one-hot or zero |

## Verification
A corrupted priority pointer shows up only at the next contended free cycle. There, the wrong master's grant appears one cycle after the requests are sampled. For that reason the bench checks every tenure's winner against a model of the rotating order. A state register stuck in the offer or owned phase shows up at once: a grant persists after the acknowledge, a grant drops without one, or a grant appears while another master still holds the bus. Each of these is visible at the next sample point after the offending edge.

// File: rtl/arbx_pkg.sv
package arbx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_OFFER = 2'd1,
      ST_HELD  = 2'd2
   } arb_state_e;

   // modular add for small values, both operands below n
   function automatic int wrap_add(input int base, input int step, input int n);
      int s;
      s = base + step;
      return (s >= n) ? s - n : s;
   endfunction

endpackage

// File: rtl/arbx_picker.sv
module arbx_picker
   import arbx_pkg::*;
#(
   parameter int N  = 3,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] top,
   output logic [N-1:0]  win,
   output logic [IW-1:0] win_idx,
   output logic          any
);

   // scan from the top-ranked master around the ring
   always_comb begin
      win     = '0;
      win_idx = '0;
      any     = 1'b0;
      for (int k = 0; k < N; k++) begin : g_scan
         int idx;
         idx = wrap_add(int'(top), k, N);
         if (!any && req[idx]) begin
            any      = 1'b1;
            win_idx  = IW'(idx);
            win[idx] = 1'b1;
         end
      end
   end

   always_comb begin
      if (any) begin
         AST_PICK_ONE_REQUESTER: assert ($onehot(win) && ((win & ~req) == '0)); // R9
      end
   end

endmodule

// File: rtl/arbx_rotor.sv
module arbx_rotor #(
   parameter int N  = 3,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [IW-1:0] top
);

   localparam logic [IW-1:0] LAST = IW'(N - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        top <= '0;
      else if (adv)      top <= (top == LAST) ? '0 : top + 1'b1;
   end

   AST_ROTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      top <= LAST); // R3

endmodule

// File: rtl/arbx_tenure.sv
module arbx_tenure
   import arbx_pkg::*;
#(
   parameter int N  = 3,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   input  logic [N-1:0]  ack_i,
   input  logic          pick_any,
   input  logic [IW-1:0] pick_idx,
   output logic [N-1:0]  gnt_o,
   output logic          rel_o
);

   arb_state_e    state;
   logic [IW-1:0] owner;
   logic          own_ack;

   assign own_ack = ack_i[owner];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         owner <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (pick_any) begin
               owner <= pick_idx;
               state <= ST_OFFER;
            end
            ST_OFFER: if (own_ack)  state <= ST_HELD;
            ST_HELD:  if (!own_ack) state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign gnt_o = (state == ST_OFFER) ? (N'(1) << owner) : '0;
   assign rel_o = (state == ST_HELD) && !own_ack;

   AST_IDLE_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && |req_i) |=> $onehot(gnt_o)); // R2

   for (genvar i = 0; i < N; i++) begin : g_chk
      AST_GRANT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt_o[i] && !ack_i[i]) |=> gnt_o[i]); // R6
      AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt_o[i] && ack_i[i]) |=> (gnt_o == '0)); // R5
   end

endmodule

// File: rtl/rot_bus_arbiter.sv
module rot_bus_arbiter #(
   parameter int N_MASTERS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_i,
   input  logic [N_MASTERS-1:0] ack_i,
   output logic [N_MASTERS-1:0] gnt_o
);

   localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

   if (N_MASTERS < 2) begin : g_bad_n
      $error("rot_bus_arbiter: N_MASTERS must be at least 2");
   end
   if (N_MASTERS > 64) begin : g_big_n
      $error("rot_bus_arbiter: N_MASTERS above 64 is not supported");
   end

   logic [IW-1:0]        top;
   logic [N_MASTERS-1:0] win;
   logic [IW-1:0]        win_idx;
   logic                 any;
   logic                 rel;

   arbx_picker #(.N(N_MASTERS), .IW(IW)) i_picker (
      .req     (req_i),
      .top     (top),
      .win     (win),
      .win_idx (win_idx),
      .any     (any)
   );

   arbx_rotor #(.N(N_MASTERS), .IW(IW)) i_rotor (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (rel),
      .top   (top)
   );

   arbx_tenure #(.N(N_MASTERS), .IW(IW)) i_tenure (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i),
      .ack_i    (ack_i),
      .pick_any (any),
      .pick_idx (win_idx),
      .gnt_o    (gnt_o),
      .rel_o    (rel)
   );

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o)); // R8
   AST_ORDER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !rel |=> $stable(top)); // R3
   AST_ORDER_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      rel |=> !$stable(top)); // R3

endmodule

// File: tb/test_rot_bus_arbiter.sv
module test_rot_bus_arbiter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] req_r = '0;
   logic [2:0] ack_r = '0;
   logic [2:0] gnt;
   int         n_chk = 0;
   int         n_bad = 0;
   int         ptr_m = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   rot_bus_arbiter #(.N_MASTERS(3)) i_rot_bus_arbiter (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req_r),
      .ack_i (ack_r),
      .gnt_o (gnt)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic int pick(input logic [2:0] r, input int p);
      for (int k = 0; k < 3; k++) begin
         if (r[(p + k) % 3]) return (p + k) % 3;
      end
      return -1;
   endfunction

   // one full tenure; requests in req_r were applied at the current negedge
   task automatic serve(input int hold, input logic [2:0] extra, input string tag);
      int w;
      w = pick(req_r, ptr_m);
      tick();
      chk(tag, gnt, 3'(1 << w));
      ack_r[w] = 1'b1;
      req_r[w] = 1'b0;
      tick();
      chk("R5 grant withdrawn after ack", gnt, 3'b000);
      req_r = req_r | extra;
      for (int h = 0; h < hold; h++) begin
         tick();
         chk("R7 no grant during tenure", gnt, 3'b000);
      end
      ack_r[w] = 1'b0;
      tick();
      chk("R4 idle cycle after release", gnt, 3'b000);
      ptr_m = (ptr_m + 1) % 3;
   endtask

   task automatic t_reset();
      tick();
      chk("R1 no grant after reset", gnt, 3'b000);
   endtask

   task automatic t_first_tie();
      req_r = 3'b111;
      serve(2, 3'b000, "R1 R9 initial order grants master 0");
      serve(1, 3'b000, "R3 R4 rotated order grants master 1");
      serve(0, 3'b000, "R4 last pending grants master 2");
      tick();
      chk("R2 no request no grant", gnt, 3'b000);
   endtask

   task automatic t_single();
      req_r = 3'b100;
      serve(1, 3'b000, "R2 lone request granted next cycle");
   endtask

   task automatic t_no_ack();
      req_r = 3'b001;
      tick();
      chk("R2 master 0 granted", gnt, 3'b001);
      req_r = 3'b000;
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R6 grant kept after request drop", gnt, 3'b001);
      end
      ack_r = 3'b110;
      tick();
      chk("R6 foreign acks ignored", gnt, 3'b001);
      ack_r = 3'b001;
      tick();
      chk("R5 grant withdrawn after ack", gnt, 3'b000);
      ack_r = 3'b000;
      tick();
      chk("R7 idle after release", gnt, 3'b000);
      ptr_m = (ptr_m + 1) % 3;
   endtask

   task automatic t_queue();
      req_r = 3'b010;
      serve(3, 3'b101, "R2 master 1 granted");
      serve(1, 3'b000, "R4 queued master 0 ranks first");
      serve(1, 3'b000, "R4 queued master 2 served next");
   endtask

   task automatic t_rotation();
      for (int r = 0; r < 3; r++) begin
         req_r = 3'b111;
         serve(1, 3'b000, "R3 R9 contended grant follows rotation");
      end
   endtask

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      t_reset();
      t_first_tie();
      t_single();
      t_no_ack();
      t_queue();
      t_rotation();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule